// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Tracker

The block keeps three vector-indexed bitmaps: one for requests that wait, one for vectors in service and one that records whether each request came in level- or edge-triggered. Vectors are grouped into priority classes of 16, and the class is the upper nibble of the vector. A task-priority register sets a floor. From that floor and the highest in-service vector the block derives a processor priority. The block then presents the highest pending vector whose class lies strictly above that priority.

The core acknowledges the presented vector, which moves it from pending to in service. When the handler finishes, the core issues an end-of-interrupt. The block then retires the highest in-service vector and, one cycle later, reports that vector and its recorded trigger mode on an outbound notification. A source posts a request through the accept port. The port reports in the same cycle whether the request was taken or discarded.

Top module: `vit_tracker`

## Requirements
- R1: After reset all three bitmaps are empty, the task priority and the processor priority read 0, no vector is presented, and no end-of-interrupt notification is raised.
- R2: An accepted request sets its pending bit. The presented vector is always the numerically highest pending vector, searched from the top 32-bit word down.
- R3: A request for a vector whose pending bit is already set raises `acc_discard_o` in that cycle and changes nothing.
- R4: While `enable_i` is low, every request is discarded and no vector is presented.
- R5: Requests for vectors 0 to 15 are always discarded, so no vector below 16 is ever presented.
- R6: The processor priority is the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that vector with its low nibble cleared. With nothing in service, the in-service vector counts as 0.
- R7: A pending vector is presented only when its value with the low nibble cleared is strictly greater than the processor priority. An equal class is therefore held back.
- R8: An acknowledge while a vector is presented sets that vector's in-service bit and clears its pending bit on the same clock edge.
- R9: An end-of-interrupt clears the highest in-service bit and its trigger-mode bit. In the next cycle `eoi_valid_o` pulses for one cycle, with that vector and with `eoi_level_o` = 1 if the vector was last accepted as level-triggered and 0 if edge-triggered.
- R10: An end-of-interrupt with nothing in service raises no notification and leaves all state unchanged.
- R11: A task-priority write stores only the low 8 bits of the write data.
- R12: An acknowledge while no vector is presented has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; requests are discarded and nothing is presented while it is low |
| acc_valid_i | input | 1 | Request strobe |
| acc_vec_i | input | 8 | Requested vector |
| acc_level_i | input | 1 | 1 = level-triggered request, 0 = edge-triggered |
| acc_discard_o | output | 1 | The current request is discarded (combinational) |
| ack_i | input | 1 | Acknowledge of the presented vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 32 | Task-priority write data |
| int_valid_o | output | 1 | A deliverable vector is presented |
| int_vec_o | output | 8 | Presented vector |
| eoi_valid_o | output | 1 | End-of-interrupt notification, one-cycle pulse |
| eoi_vec_o | output | 8 | Retired vector |
| eoi_level_o | output | 1 | Recorded trigger mode of the retired vector |
| tpr_o | output | 8 | Current task priority |
| ppr_o | output | 8 | Current processor priority |

## Verification
The bench builds the block with its default parameters: 256 vectors in eight 32-bit words, with the lowest 16 vectors reserved. At these values the search reaches the top word (vector 0xE5) and a word in the middle (0x23), and the reserved range can be hit with vector 0x0F. Nested service of 0x90 over 0x41 tests the in-service search and the recomputation of priority at each retirement. Task-priority values are chosen to equal, undercut and exceed the pending class, which brings the strict-greater boundary within reach.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int unsigned CLASS_W = 4;  // priority class = upper nibble of a vector
  localparam int unsigned TPR_W   = 8;
endpackage

// File: rtl/vit_find_hi.sv
module vit_find_hi #(
  parameter int unsigned N      = 256,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(N),
  localparam int unsigned NW    = N / WORD_W,
  localparam int unsigned POS_W = $clog2(WORD_W)
) (
  input  logic [N-1:0]     bits_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NW-1:0]    w_any;
  logic [POS_W-1:0] w_pos [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WORD_W-1:0] word;
    assign word     = bits_i[w*WORD_W +: WORD_W];
    assign w_any[w] = |word;
    always_comb begin
      w_pos[w] = '0;
      for (int b = 0; b < WORD_W; b++)
        if (word[b]) w_pos[w] = POS_W'(b);
    end
  end

  // top word wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int w = 0; w < NW; w++)
      if (w_any[w]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(w * WORD_W) | IDX_W'(w_pos[w]);
      end
  end
endmodule

// File: rtl/vit_prio_calc.sv
module vit_prio_calc
  import vit_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic [TPR_W-1:0] tpr_i,
  input  logic             isr_found_i,
  input  logic [VEC_W-1:0] isr_vec_i,
  output logic [TPR_W-1:0] ppr_o
);
  logic [VEC_W-1:0]   isrv;
  logic [CLASS_W-1:0] isr_cls, tpr_cls;

  assign isrv    = isr_found_i ? isr_vec_i : '0;
  assign isr_cls = isrv[VEC_W-1 -: CLASS_W];
  assign tpr_cls = tpr_i[TPR_W-1 -: CLASS_W];
  assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {(TPR_W-CLASS_W){1'b0}}};
endmodule

// File: rtl/vit_tracker.sv
module vit_tracker
  import vit_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned MIN_VEC = 16,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             acc_valid_i,
  input  logic [VEC_W-1:0] acc_vec_i,
  input  logic             acc_level_i,
  output logic             acc_discard_o,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic             tpr_we_i,
  input  logic [31:0]      tpr_wdata_i,
  output logic             int_valid_o,
  output logic [VEC_W-1:0] int_vec_o,
  output logic             eoi_valid_o,
  output logic [VEC_W-1:0] eoi_vec_o,
  output logic             eoi_level_o,
  output logic [TPR_W-1:0] tpr_o,
  output logic [TPR_W-1:0] ppr_o
);
  localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VEC);

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic [TPR_W-1:0]   tpr_q;

  logic             irr_found, isr_found;
  logic [VEC_W-1:0] irr_hi, isr_hi;
  logic [TPR_W-1:0] ppr;
  logic             acc_take, ack_fire, eoi_fire;

  vit_find_hi #(.N(NUM_VEC), .WORD_W(WORD_W)) u_irr_hi (
    .bits_i(irr_q), .found_o(irr_found), .idx_o(irr_hi)
  );
  vit_find_hi #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isr_hi (
    .bits_i(isr_q), .found_o(isr_found), .idx_o(isr_hi)
  );
  vit_prio_calc #(.VEC_W(VEC_W)) u_ppr (
    .tpr_i(tpr_q), .isr_found_i(isr_found), .isr_vec_i(isr_hi), .ppr_o(ppr)
  );

  assign int_vec_o   = irr_hi;
  assign int_valid_o = enable_i && irr_found &&
                       ({irr_hi[VEC_W-1 -: CLASS_W], {(VEC_W-CLASS_W){1'b0}}} > ppr);

  assign acc_discard_o = acc_valid_i && (!enable_i || irr_q[acc_vec_i] || acc_vec_i < MIN_V);
  assign acc_take      = acc_valid_i && !acc_discard_o;
  assign ack_fire      = ack_i && int_valid_o;
  assign eoi_fire      = eoi_i && isr_found;

  // order: acknowledge, retire, then accept
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_fire) begin
      isr_d[irr_hi] = 1'b1;
      irr_d[irr_hi] = 1'b0;
    end
    if (eoi_fire) begin
      isr_d[isr_hi] = 1'b0;
      tmr_d[isr_hi] = 1'b0;
    end
    if (acc_take) begin
      irr_d[acc_vec_i] = 1'b1;
      tmr_d[acc_vec_i] = acc_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      tpr_q       <= '0;
      eoi_valid_o <= 1'b0;
      eoi_vec_o   <= '0;
      eoi_level_o <= 1'b0;
    end else begin
      irr_q       <= irr_d;
      isr_q       <= isr_d;
      tmr_q       <= tmr_d;
      if (tpr_we_i) tpr_q <= tpr_wdata_i[TPR_W-1:0];
      eoi_valid_o <= eoi_fire;
      if (eoi_fire) begin
        eoi_vec_o   <= isr_hi;
        eoi_level_o <= tmr_q[isr_hi];
      end
    end
  end

  assign tpr_o = tpr_q;
  assign ppr_o = ppr;
endmodule

// File: rtl/vit_tracker_chk.sv
module vit_tracker_chk #(
  parameter int unsigned NUM_VEC = 256,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               acc_valid_i,
  input logic [VEC_W-1:0]   acc_vec_i,
  input logic               acc_discard_o,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               int_valid_o,
  input logic [VEC_W-1:0]   int_vec_o,
  input logic               eoi_valid_o,
  input logic [7:0]         tpr_o,
  input logic [7:0]         ppr_o,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q
);
  assert_dup_discard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && irr_q[acc_vec_i]) |-> acc_discard_o);

  assert_off_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !int_valid_o);

  assert_no_low_vec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_valid_o |-> int_vec_o >= VEC_W'(16));

  assert_ppr_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[7:4] >= tpr_o[7:4]);

  assert_class_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_valid_o |-> {int_vec_o[7:4], 4'h0} > ppr_o);

  assert_ack_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_valid_o) |=> (isr_q[$past(int_vec_o)] && !irr_q[$past(int_vec_o)]));

  assert_empty_eoi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(|isr_q)) |=> !eoi_valid_o);
endmodule

bind vit_tracker vit_tracker_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
  .acc_valid_i(acc_valid_i), .acc_vec_i(acc_vec_i), .acc_discard_o(acc_discard_o),
  .ack_i(ack_i), .eoi_i(eoi_i), .int_valid_o(int_valid_o), .int_vec_o(int_vec_o),
  .eoi_valid_o(eoi_valid_o), .tpr_o(tpr_o), .ppr_o(ppr_o),
  .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/vit_tracker_tb.sv
module vit_tracker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [7:0]  acc_vec_i = '0;
  logic        acc_level_i = 1'b0;
  logic        acc_discard_o;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic        tpr_we_i = 1'b0;
  logic [31:0] tpr_wdata_i = '0;
  logic        int_valid_o;
  logic [7:0]  int_vec_o;
  logic        eoi_valid_o;
  logic [7:0]  eoi_vec_o;
  logic        eoi_level_o;
  logic [7:0]  tpr_o, ppr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  vit_tracker u_dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // inputs change 1 ns after a rising edge; results sampled 1 ns later
  task automatic tick();
    @(posedge clk_i); #1;
    acc_valid_i = 0; ack_i = 0; eoi_i = 0; tpr_we_i = 0;
    #1;
  endtask

  task automatic accept(input logic [7:0] v, input logic lvl, input int exp_disc, string req);
    acc_valid_i = 1; acc_vec_i = v; acc_level_i = lvl;
    #1 check(req, acc_discard_o, exp_disc);
    tick();
  endtask

  task automatic expect_int(string req, int valid, int vec);
    check(req, int_valid_o, valid);
    if (valid != 0) check(req, int_vec_o, vec);
  endtask

  task automatic ack();  ack_i = 1; tick(); endtask
  task automatic eoi();  eoi_i = 1; tick(); endtask
  task automatic wtpr(input logic [31:0] d); tpr_we_i = 1; tpr_wdata_i = d; tick(); endtask

  task automatic t_reset();
    check("R1 int_valid", int_valid_o, 0);
    check("R1 tpr", tpr_o, 0);
    check("R1 ppr", ppr_o, 0);
    check("R1 eoi_valid", eoi_valid_o, 0);
  endtask

  task automatic t_accept();
    enable_i = 1;
    accept(8'h40, 0, 0, "R2 take 40");
    expect_int("R2 first", 1, 8'h40);
    accept(8'h41, 0, 0, "R2 take 41");
    expect_int("R2 higher bit", 1, 8'h41);
    accept(8'h23, 0, 0, "R2 take 23");
    expect_int("R2 lower word", 1, 8'h41);
    accept(8'hE5, 0, 0, "R2 take E5");
    expect_int("R2 top word", 1, 8'hE5);
    accept(8'h41, 1, 1, "R3 duplicate");
    expect_int("R3 unchanged", 1, 8'hE5);
    accept(8'h0F, 0, 1, "R5 low vector");
    expect_int("R5 unchanged", 1, 8'hE5);
  endtask

  task automatic t_ack_eoi();
    ack();
    check("R6 ppr from isr", ppr_o, 8'hE0);
    expect_int("R7 class blocked", 0, 0);
    eoi();
    check("R9 eoi_valid", eoi_valid_o, 1);
    check("R9 eoi_vec", eoi_vec_o, 8'hE5);
    check("R9 edge", eoi_level_o, 0);
    check("R9 ppr back", ppr_o, 0);
    expect_int("R8 pending cleared", 1, 8'h41);
    #4 check("R9 pulse ends", eoi_valid_o, 0);
  endtask

  task automatic t_level_tpr();
    accept(8'h90, 1, 0, "R2 take 90 level");
    expect_int("R2 90", 1, 8'h90);
    ack();
    check("R6 ppr 90", ppr_o, 8'h90);
    wtpr(32'hABCD_12A5);
    check("R11 low byte", tpr_o, 8'hA5);
    check("R6 tpr wins", ppr_o, 8'hA5);
    wtpr(32'h30);
    check("R6 isr wins", ppr_o, 8'h90);
    eoi();
    check("R9 level vec", eoi_vec_o, 8'h90);
    check("R9 level", eoi_level_o, 1);
    check("R6 ppr tpr", ppr_o, 8'h30);
    expect_int("R7 above", 1, 8'h41);
    wtpr(32'h41);
    expect_int("R7 equal class held", 0, 0);
    wtpr(32'h3F);
    expect_int("R7 below", 1, 8'h41);
  endtask

  task automatic t_nested();
    ack();
    check("R6 nested ppr", ppr_o, 8'h40);
    expect_int("R7 40 held", 0, 0);
    accept(8'h90, 0, 0, "R2 take 90 edge");
    expect_int("R7 90 over 41", 1, 8'h90);
    ack();
    eoi();
    check("R9 highest first", eoi_vec_o, 8'h90);
    check("R9 trigger rewritten", eoi_level_o, 0);
    eoi();
    check("R9 second", eoi_vec_o, 8'h41);
    check("R9 second valid", eoi_valid_o, 1);
    eoi();
    check("R10 empty eoi", eoi_valid_o, 0);
    check("R10 ppr", ppr_o, 8'h3F);
    expect_int("R10 pending kept", 1, 8'h40);
  endtask

  task automatic t_stray_ack();
    wtpr(32'hF0);
    expect_int("R12 blocked", 0, 0);
    ack();
    wtpr(32'h00);
    check("R12 isr untouched", ppr_o, 0);
    expect_int("R12 pending kept", 1, 8'h40);
  endtask

  task automatic t_disable();
    enable_i = 0;
    #1 expect_int("R4 hidden", 0, 0);
    accept(8'h70, 0, 1, "R4 discard");
    enable_i = 1;
    #1 expect_int("R4 not recorded", 1, 8'h40);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    #1;
    t_reset();
    t_accept();
    t_ack_eoi();
    t_level_tpr();
    t_nested();
    t_stray_ack();
    t_disable();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule